// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Status Flags

This block holds outgoing audio samples between a register-write port and a serial shifter. Each data write pushes one 32-bit word. Each pop request from the shifter removes the oldest word, which the block presents combinationally on its output. Both pointers carry an extra wrap bit, so the full and empty states can be told apart, and both pointers can be read back as status.

Three conditions are reported. The first is a request flag, raised while the number of free entries is greater than a programmable threshold. The second is a warning flag, raised while the channel is enabled and the FIFO is empty. The third is a sticky error flag for underrun, which is cleared by writing a one to it. A single interrupt line combines all enabled flags. The request and warning conditions each have their own DMA request line. A flush strobe returns both pointers to zero.

Top module: `audio_tx_fifo`

## Requirements
- R1: A push (`wr_en`=1) while fewer than 8 words are held stores `wr_data` and advances `wr_ptr` by one, modulo 16, at the next clock edge.
- R2: While the FIFO is not empty, `pop_data` shows the oldest stored word. A pop (`pop_req`=1) advances `rd_ptr` by one, modulo 16, so words leave in the order they were written.
- R3: A push while 8 words are held is dropped. `wr_ptr` does not move and no stored word changes.
- R4: While the FIFO is empty, `pop_data` is all zeros. A pop while empty leaves both pointers unchanged and sets `err_flag` at the next edge.
- R5: `err_flag` stays set until a cycle with `err_clr`=1, which clears it at the next edge. A cycle with `err_clr`=0 leaves it unchanged. If an underrun and `err_clr` fall in the same cycle, the flag ends set.
- R6: `req_flag` equals (8 − level) > `watermark`, where level = (`wr_ptr` − `rd_ptr`) mod 16.
- R7: `warn_flag` equals `tx_en` AND (level = 0).
- R8: `irq` is the OR of `req_flag`&`ie_req`, `warn_flag`&`ie_warn` and `err_flag`&`ie_err`.
- R9: `dma_req` = `req_flag`&`de_req`, and `dma_warn` = `warn_flag`&`de_warn`.
- R10: `fifo_rst`=1 sets both pointers to 0 at the next edge. It overrides a push or pop in the same cycle and leaves `err_flag` unchanged.
- R11: A push and a pop in the same cycle both take effect when the FIFO is neither full nor empty, and the level stays the same. At empty, the push is stored and the pop counts as an underrun. At full, the pop is taken and the push is dropped.
- R12: After reset, both pointers are 0 and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 32 | Word to push |
| pop_req | input | 1 | Pop request from the shifter |
| pop_data | output | 32 | Oldest word, or zero when empty |
| fifo_rst | input | 1 | Flush strobe for both pointers |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| watermark | input | 3 | Request threshold on free entries |
| tx_en | input | 1 | Channel enable for the warning flag |
| ie_req | input | 1 | Interrupt enable, request flag |
| ie_warn | input | 1 | Interrupt enable, warning flag |
| ie_err | input | 1 | Interrupt enable, error flag |
| de_req | input | 1 | DMA enable, request flag |
| de_warn | input | 1 | DMA enable, warning flag |
| req_flag | output | 1 | Free entries exceed watermark |
| warn_flag | output | 1 | Enabled FIFO is empty |
| err_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | DMA request from request flag |
| dma_warn | output | 1 | DMA request from warning flag |
| wr_ptr | output | 4 | Write pointer with wrap bit |
| rd_ptr | output | 4 | Read pointer with wrap bit |

## Verification
Two groups of events can collide in one cycle. The first is an underrun setting the error flag while software writes one to clear it. The second is a push meeting a pop at the empty boundary or at the full boundary. The bench creates each collision directly: it pops an empty FIFO with `err_clr` high, and it pushes and pops together at levels 0, 4 and 8. A reference model outside the design then checks the pointers, the error flag and the data that leaves the FIFO. The bench also sweeps every watermark against every level, and every combination of the enables against each flag state.

// File: rtl/atf_pkg.sv
package atf_pkg;
  localparam int unsigned ATF_DATA_W = 32;
  localparam int unsigned ATF_ADDR_W = 3;
endpackage

// File: rtl/atf_rst_sync.sv
module atf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/atf_ptrs.sv
module atf_ptrs #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] level,
  output logic             empty,
  output logic             push_ok,
  output logic             underrun
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0] wr_q, rd_q, wr_n, rd_n;
  logic             full, pop_ok, ptr_en;

  assign level    = wr_q - rd_q;
  assign full     = (level == DEPTH_P);
  assign empty    = (level == '0);
  assign push_ok  = push & ~full & ~flush;
  assign pop_ok   = pop & ~empty & ~flush;
  assign underrun = pop & empty;
  assign ptr_en   = flush | push_ok | pop_ok;

  always_comb begin
    wr_n = wr_q;
    rd_n = rd_q;
    if (flush) begin
      wr_n = '0;
      rd_n = '0;
    end else begin
      if (push_ok) wr_n = wr_q + 1'b1;
      if (pop_ok)  rd_n = rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (ptr_en) begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
endmodule

// File: rtl/atf_store.sv
module atf_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    logic              cell_en;
    logic [DATA_W-1:0] cell_q;

    assign cell_en = we & (waddr == IDX);

    always_ff @(posedge clk) begin
      if (cell_en) cell_q <= wdata;
    end

    assign word_arr[g] = cell_q;
  end

  assign rdata = word_arr[raddr];
endmodule

// File: rtl/atf_status.sv
module atf_status #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  level,
  input  logic [ADDR_W-1:0] watermark,
  input  logic              tx_en,
  input  logic              underrun,
  input  logic              err_clr,
  input  logic              ie_req,
  input  logic              ie_warn,
  input  logic              ie_err,
  input  logic              de_req,
  input  logic              de_warn,
  output logic              req_flag,
  output logic              warn_flag,
  output logic              err_flag,
  output logic              irq,
  output logic              dma_req,
  output logic              dma_warn
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0] free_cnt;
  logic             err_q, err_n, err_en;

  assign free_cnt  = DEPTH_P - level;
  assign req_flag  = (free_cnt > PTR_W'(watermark));
  assign warn_flag = tx_en & (level == '0);

  assign err_en = underrun | err_clr;

  always_comb begin
    err_n = err_q;
    if (err_clr)  err_n = 1'b0;
    if (underrun) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_n;
  end

  assign err_flag = err_q;
  assign irq      = (req_flag & ie_req) | (warn_flag & ie_warn) | (err_q & ie_err);
  assign dma_req  = req_flag & de_req;
  assign dma_warn = warn_flag & de_warn;
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import atf_pkg::*;
#(
  parameter int unsigned DATA_W = ATF_DATA_W,
  parameter int unsigned ADDR_W = ATF_ADDR_W,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  input  logic              fifo_rst,
  input  logic              err_clr,
  input  logic [ADDR_W-1:0] watermark,
  input  logic              tx_en,
  input  logic              ie_req,
  input  logic              ie_warn,
  input  logic              ie_err,
  input  logic              de_req,
  input  logic              de_warn,
  output logic              req_flag,
  output logic              warn_flag,
  output logic              err_flag,
  output logic              irq,
  output logic              dma_req,
  output logic              dma_warn,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr
);
  logic              rst_sync_n;
  logic [PTR_W-1:0]  level;
  logic              empty, push_ok, underrun;
  logic [DATA_W-1:0] head_word;

  atf_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  atf_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_sync_n), .push(wr_en), .pop(pop_req),
    .flush(fifo_rst), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level),
    .empty(empty), .push_ok(push_ok), .underrun(underrun)
  );

  atf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr[ADDR_W-1:0]), .wdata(wr_data),
    .raddr(rd_ptr[ADDR_W-1:0]), .rdata(head_word)
  );

  atf_status #(.ADDR_W(ADDR_W)) u_status (
    .clk(clk), .rst_n(rst_sync_n), .level(level), .watermark(watermark),
    .tx_en(tx_en), .underrun(underrun), .err_clr(err_clr),
    .ie_req(ie_req), .ie_warn(ie_warn), .ie_err(ie_err),
    .de_req(de_req), .de_warn(de_warn), .req_flag(req_flag),
    .warn_flag(warn_flag), .err_flag(err_flag), .irq(irq),
    .dma_req(dma_req), .dma_warn(dma_warn)
  );

  assign pop_data = empty ? '0 : head_word;
endmodule

// File: rtl/atf_checker.sv
module atf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              pop_req,
  input logic              fifo_rst,
  input logic              err_clr,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [DATA_W-1:0] pop_data,
  input logic              err_flag
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0] lvl;
  logic             is_full, is_empty;

  assign lvl      = wr_ptr - rd_ptr;
  assign is_full  = (lvl == DEPTH_P);
  assign is_empty = (lvl == '0);

  // R1
  push_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_full && !fifo_rst) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));

  // R2
  pop_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !is_empty && !fifo_rst) |=> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_full && !fifo_rst) |=> $stable(wr_ptr));

  // R4
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> (pop_data == '0));

  // R4
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && is_empty) |=> err_flag);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> (wr_ptr == '0 && rd_ptr == '0));

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= DEPTH_P);
endmodule

bind audio_tx_fifo atf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .pop_req(pop_req),
  .fifo_rst(fifo_rst), .err_clr(err_clr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .pop_data(pop_data), .err_flag(err_flag)
);

// File: tb/test_audio_tx_fifo.sv
module test_audio_tx_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, pop_req, fifo_rst, err_clr, tx_en;
  logic [31:0] wr_data, pop_data;
  logic [2:0]  watermark;
  logic        ie_req, ie_warn, ie_err, de_req, de_warn;
  logic        req_flag, warn_flag, err_flag, irq, dma_req, dma_warn;
  logic [3:0]  wr_ptr, rd_ptr;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdat [8];
  int mw, mr, dctr;
  bit merr;

  always #4 clk = ~clk;

  audio_tx_fifo i_audio_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pop_req(pop_req), .pop_data(pop_data), .fifo_rst(fifo_rst),
    .err_clr(err_clr), .watermark(watermark), .tx_en(tx_en),
    .ie_req(ie_req), .ie_warn(ie_warn), .ie_err(ie_err),
    .de_req(de_req), .de_warn(de_warn), .req_flag(req_flag),
    .warn_flag(warn_flag), .err_flag(err_flag), .irq(irq),
    .dma_req(dma_req), .dma_warn(dma_warn), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lvl();
    return (mw - mr + 16) % 16;
  endfunction

  task automatic check_state();
    int  l  = lvl();
    bit  rq = ((8 - l) > int'(watermark));
    bit  wn = tx_en && (l == 0);
    chk("R1 wr_ptr", 32'(wr_ptr), 32'(mw));
    chk("R2 rd_ptr", 32'(rd_ptr), 32'(mr));
    chk("R5 err_flag", 32'(err_flag), 32'(merr));
    chk("R6 req_flag", 32'(req_flag), 32'(rq));
    chk("R7 warn_flag", 32'(warn_flag), 32'(wn));
    chk("R8 irq", 32'(irq), 32'((rq & ie_req) | (wn & ie_warn) | (merr & ie_err)));
    chk("R9 dma_req", 32'(dma_req), 32'(rq & de_req));
    chk("R9 dma_warn", 32'(dma_warn), 32'(wn & de_warn));
    chk("R4 pop_data", pop_data, (l == 0) ? 32'h0 : mdat[mr % 8]);
  endtask

  // Called at a falling edge; drives one cycle and checks the result.
  task automatic cycle(bit push, bit pop, bit flush, bit clr);
    int l = lvl();
    wr_en = push; pop_req = pop; fifo_rst = flush; err_clr = clr;
    wr_data = 32'hC0DE_0000 + 32'(dctr);
    #1;
    chk("R2 pop_data live", pop_data, (l == 0) ? 32'h0 : mdat[mr % 8]);
    if (pop && l == 0) merr = 1'b1;
    else if (clr)      merr = 1'b0;
    if (flush) begin
      mw = 0; mr = 0;
    end else begin
      if (push && l < 8) begin mdat[mw % 8] = wr_data; mw = (mw + 1) % 16; end
      if (pop && l > 0)  mr = (mr + 1) % 16;
    end
    dctr++;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; pop_req = 1'b0; fifo_rst = 1'b0; err_clr = 1'b0;
    #1;
    check_state();
  endtask

  task automatic set_en(int e);
    {de_warn, de_req, ie_err, ie_warn, ie_req} = 5'(e);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; pop_req = 0; fifo_rst = 0; err_clr = 0;
    wr_data = 0; watermark = 3'd0; tx_en = 1'b0; set_en(0);
    mw = 0; mr = 0; merr = 0; dctr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R12 reset state
    chk("R12 wr_ptr", 32'(wr_ptr), 0);
    chk("R12 rd_ptr", 32'(rd_ptr), 0);
    chk("R12 err_flag", 32'(err_flag), 0);
    check_state();

    // R6 R3: every watermark against every level, then overfill
    tx_en = 1'b1;
    for (int w = 0; w < 8; w++) begin
      watermark = 3'(w);
      @(negedge clk);
      cycle(0, 0, 1, 0);
      for (int k = 0; k < 10; k++) cycle(1, 0, 0, 0);
    end

    // R2 drain in order, R4 underrun past empty
    for (int k = 0; k < 8; k++) cycle(0, 1, 0, 0);
    cycle(0, 1, 0, 0);
    chk("R4 err after underrun", 32'(err_flag), 1);

    // R5 clear, zero write, collision of set and clear
    cycle(0, 0, 0, 0);
    cycle(0, 0, 0, 1);
    chk("R5 cleared", 32'(err_flag), 0);
    cycle(0, 1, 0, 1);
    chk("R5 set wins over clear", 32'(err_flag), 1);

    // R11 push and pop together at empty, mid, full
    cycle(0, 0, 1, 1);
    cycle(1, 1, 0, 0);
    for (int k = 0; k < 3; k++) cycle(1, 0, 0, 0);
    cycle(1, 1, 0, 0);
    chk("R11 level kept at mid", 32'(lvl()), 4);
    for (int k = 0; k < 4; k++) cycle(1, 0, 0, 0);
    cycle(1, 1, 0, 0);
    chk("R11 full push dropped", 32'(lvl()), 7);

    // R10 flush beats push and pop, error untouched
    cycle(0, 1, 1, 0);
    cycle(0, 1, 0, 0);
    cycle(1, 0, 0, 0);
    cycle(1, 1, 1, 0);
    chk("R10 flushed", 32'(wr_ptr), 0);
    chk("R10 err kept", 32'(err_flag), 1);

    // R8 R9 all enable combinations in two flag states
    watermark = 3'd3;
    for (int e = 0; e < 32; e++) begin set_en(e); cycle(0, 0, 0, 0); end
    cycle(0, 0, 0, 1);
    for (int k = 0; k < 6; k++) cycle(1, 0, 0, 0);
    for (int e = 0; e < 32; e++) begin set_en(e); cycle(0, 0, 0, 0); end

    // R7 warning gated by channel enable
    cycle(0, 0, 1, 0);
    tx_en = 1'b0; set_en(31);
    cycle(0, 0, 0, 0);
    chk("R7 warn off when disabled", 32'(warn_flag), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule